// File: doc/BRIEF.md
# Secure Region Permission Checker

This block decides, in the same cycle, whether a memory access may proceed. Each access presents an address, a flag saying whether it is a write, and a flag saying whether it comes from the secure world. The block compares the address against a small table of programmable regions. Each region has a base address, a power-of-two size and a four-bit permission nibble. The winning region's nibble then grants or refuses the access.

Software sets up the table through a plain 32-bit register port with single-cycle writes and combinational reads. For each region there is a low base word, a high base word and an attribute word holding an enable flag, a size code and the permission nibble. A fixed read-only word reports how many regions exist and how wide the address is. A one-bit security-inversion setting can be stored and read back.

Region 0 is the background. It covers the whole address space, so every access has a decision. Higher-numbered regions overlay it, and the highest-numbered one that matches wins.

Top module: `region_guard`

## Requirements
- R1: After reset every region word and the inversion word read as zero, and every access is denied.
- R2: Offset 0x000 reads as (region count − 1) in bits 3:0 and (address width − 1) in bits 13:8, with all other bits zero. Writes to it have no effect.
- R3: Region n's words sit at 0x100 + 0x10·n (base bits 31:0), 0x104 + 0x10·n (base bits 63:32) and 0x108 + 0x10·n (attribute). The word at 0x10C + 0x10·n reads zero. Base bits at or above the address width read zero. The attribute word keeps bit 0 (enable), bits 6:1 (size code) and bits 31:28 (permissions) and reads zero elsewhere.
- R4: A region numbered 1 or higher with its enable bit clear never matches.
- R5: An enabled region with effective size code s matches when the access address and the stored base agree in every bit from position s+1 upward. When s+1 reaches the address width, the region matches every address.
- R6: A size code below 14 behaves exactly as code 14, which covers 32 KB. The stored code still reads back as written.
- R7: When several regions match, the highest-numbered one alone decides.
- R8: Region 0 matches every address, whatever its enable bit, base and size.
- R9: In the deciding region's attribute word, bit 28 grants non-secure writes, bit 29 non-secure reads, bit 30 secure writes and bit 31 secure reads. An access is allowed only when its own bit is set.
- R10: The decision is a combinational function of the access inputs and the stored registers. A register write changes decisions from the cycle after the write is accepted, and not before.
- R11: Writes to region numbers at or above the region count are ignored, and reads of them return zero. Offsets that are not word aligned, or that are not mapped, read zero, and writes to them are ignored.
- R12: Offset 0x034 bit 0 holds the security-inversion setting and reads back as written, with all other bits zero. It does not change decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| acc_addr | input | ADDR_W | Address of the access being checked |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_secure | input | 1 | 1 for a secure access, 0 for non-secure |
| acc_allow | output | 1 | 1 when the access is permitted |

## Verification
The bench builds the block with 5 regions and a 40-bit address. Region numbers 5 to 15 then fall inside the register map but beyond the table, which exercises the ignore-and-read-zero path. A 40-bit address makes high base bits truncate on readback. Size codes of 39 and above cover the whole space, and random codes from 10 to 23 reach both the clamp below 14 and real region boundaries. Random bases and addresses are drawn from a narrow window, so overlapping regions and the highest-number-wins rule come up often.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    localparam int MAX_AW        = 64;
    localparam int REG_W         = 32;
    localparam int SIZE_W        = 6;
    localparam int PERM_W        = 4;
    localparam int MIN_SIZE_CODE = 14;
    localparam int MAX_REGIONS   = 16;
    localparam int OFS_W         = 12;

    // Word selector inside one region's 16-byte slot
    localparam logic [1:0] SLOT_BASE_LO = 2'd0;
    localparam logic [1:0] SLOT_BASE_HI = 2'd1;
    localparam logic [1:0] SLOT_ATTR    = 2'd2;

    localparam logic [OFS_W-1:0] OFS_BUILD = 12'h000;
    localparam logic [OFS_W-1:0] OFS_INV   = 12'h034;
    localparam logic [3:0]       PAGE_RGN  = 4'h1;

    typedef struct packed {
        logic [MAX_AW-1:0] base;
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [PERM_W-1:0] perm;
    } rgn_cfg_t;

endpackage

// File: rtl/rg_regs.sv
module rg_regs
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 9,
    parameter int ADDR_W      = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [OFS_W-1:0]                 reg_addr,
    input  logic [REG_W-1:0]                 reg_wdata,
    output logic [REG_W-1:0]                 reg_rdata,
    output rgn_cfg_t [NUM_REGIONS-1:0]       rgn_cfg
);

    localparam int SEL_W = $clog2(NUM_REGIONS);
    localparam logic [3:0] LAST_IDX = 4'(NUM_REGIONS - 1);
    localparam logic [MAX_AW-1:0] BASE_MASK = {MAX_AW{1'b1}} >> (MAX_AW - ADDR_W);
    localparam logic [REG_W-1:0] BUILD_WORD =
        {18'd0, 6'(ADDR_W - 1), 4'd0, 4'(NUM_REGIONS - 1)};

    typedef struct packed {
        rgn_cfg_t [NUM_REGIONS-1:0] rgn;
        logic                       inv;
    } state_t;

    state_t st_d, st_q;

    logic             aligned;
    logic             in_rgn_page;
    logic [3:0]       rgn_idx;
    logic             idx_ok;
    logic [SEL_W-1:0] idx_sel;
    logic [1:0]       slot;
    logic             hit_rgn;
    logic             hit_inv;
    logic             hit_build;

    always_comb begin
        aligned     = (reg_addr[1:0] == 2'b00);
        in_rgn_page = (reg_addr[11:8] == PAGE_RGN);
        rgn_idx     = reg_addr[7:4];
        slot        = reg_addr[3:2];
        idx_ok      = (rgn_idx <= LAST_IDX);
        idx_sel     = rgn_idx[SEL_W-1:0];
        hit_rgn     = aligned && in_rgn_page && idx_ok;
        hit_inv     = aligned && (reg_addr == OFS_INV);
        hit_build   = aligned && (reg_addr == OFS_BUILD);
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            if (hit_inv) begin
                st_d.inv = reg_wdata[0];
            end else if (hit_rgn) begin
                case (slot)
                    SLOT_BASE_LO: st_d.rgn[idx_sel].base[31:0]  = reg_wdata & BASE_MASK[31:0];
                    SLOT_BASE_HI: st_d.rgn[idx_sel].base[63:32] = reg_wdata & BASE_MASK[63:32];
                    SLOT_ATTR: begin
                        st_d.rgn[idx_sel].en   = reg_wdata[0];
                        st_d.rgn[idx_sel].size = reg_wdata[6:1];
                        st_d.rgn[idx_sel].perm = reg_wdata[31:28];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Combinational read path
    always_comb begin
        reg_rdata = '0;
        if (hit_build) begin
            reg_rdata = BUILD_WORD;
        end else if (hit_inv) begin
            reg_rdata = {31'd0, st_q.inv};
        end else if (hit_rgn) begin
            case (slot)
                SLOT_BASE_LO: reg_rdata = st_q.rgn[idx_sel].base[31:0];
                SLOT_BASE_HI: reg_rdata = st_q.rgn[idx_sel].base[63:32];
                SLOT_ATTR:    reg_rdata = {st_q.rgn[idx_sel].perm, 21'd0,
                                           st_q.rgn[idx_sel].size, st_q.rgn[idx_sel].en};
                default:      reg_rdata = '0;
            endcase
        end
    end

    assign rgn_cfg = st_q.rgn;

    // R11: a write aimed past the last region leaves the table untouched
    p_oob_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && in_rgn_page && !idx_ok) |=> $stable(st_q.rgn));

    // R10: an attribute write is visible in the stored permissions next cycle
    p_attr_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_rgn && slot == SLOT_ATTR)
        |=> (st_q.rgn[$past(idx_sel)].perm == $past(reg_wdata[31:28])));

endmodule

// File: rtl/rg_region_match.sv
module rg_region_match
    import region_guard_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter bit IS_BG  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_AW-1:0] base,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              en,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit
);

    logic [SIZE_W-1:0] eff_size;
    logic [MAX_AW-1:0] keep;
    logic [MAX_AW-1:0] diff;
    logic              addr_eq;

    always_comb begin
        eff_size = (size_code < SIZE_W'(MIN_SIZE_CODE)) ? SIZE_W'(MIN_SIZE_CODE) : size_code;
        for (int b = 0; b < MAX_AW; b++) begin
            keep[b] = (b > int'(eff_size));
        end
        diff    = (MAX_AW'(acc_addr) ^ base) & keep;
        addr_eq = (diff == '0);
        hit     = IS_BG || (en && addr_eq);
    end

    // R4: a disabled overlay region must not claim any access
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_BG && !en) |-> !hit);

endmodule

// File: rtl/rg_priority.sv
module rg_priority
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 9
) (
    input  logic [NUM_REGIONS-1:0]             hit,
    input  logic [NUM_REGIONS-1:0][PERM_W-1:0] perm,
    input  logic                               acc_write,
    input  logic                               acc_secure,
    output logic                               allow
);

    logic [PERM_W-1:0] win_perm;

    always_comb begin
        win_perm = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) begin
                win_perm = perm[i];
            end
        end
        // index: secure read 3, secure write 2, non-secure read 1, non-secure write 0
        allow = win_perm[{acc_secure, ~acc_write}];
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 9,
    parameter int ADDR_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_secure,
    output logic              acc_allow
);

    rgn_cfg_t [NUM_REGIONS-1:0]             rgn_cfg;
    logic     [NUM_REGIONS-1:0]             hit;
    logic     [NUM_REGIONS-1:0][PERM_W-1:0] perm;

    rg_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rgn_cfg   (rgn_cfg)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        rg_region_match #(
            .ADDR_W (ADDR_W),
            .IS_BG  (g == 0)
        ) i_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .base      (rgn_cfg[g].base),
            .size_code (rgn_cfg[g].size),
            .en        (rgn_cfg[g].en),
            .acc_addr  (acc_addr),
            .hit       (hit[g])
        );
        assign perm[g] = rgn_cfg[g].perm;
    end

    rg_priority #(
        .NUM_REGIONS (NUM_REGIONS)
    ) i_prio (
        .hit        (hit),
        .perm       (perm),
        .acc_write  (acc_write),
        .acc_secure (acc_secure),
        .allow      (acc_allow)
    );

    // Checker state: has any register write happened since reset
    logic written_d, written_q;

    always_comb begin
        written_d = written_q | reg_we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written_q <= 1'b0;
        end else begin
            written_q <= written_d;
        end
    end

    // R1: with untouched registers, nothing is allowed
    p_reset_deny_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !written_q |-> !acc_allow);

    // R10: with no write in the previous cycle and steady inputs, the decision holds
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!reg_we) && $stable(acc_addr) && $stable(acc_write) && $stable(acc_secure))
        |-> $stable(acc_allow));

endmodule

// File: tb/test_region_guard.sv
module test_region_guard;

    localparam int NR = 5;
    localparam int AW = 40;
    localparam time CLK_P = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_write = 1'b0;
    logic          acc_secure = 1'b0;
    logic          acc_allow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state
    logic [63:0] m_base [16];
    logic        m_en   [16];
    logic [5:0]  m_size [16];
    logic [3:0]  m_perm [16];
    logic        m_inv;

    always #(CLK_P/2) clk = ~clk;

    region_guard #(.NUM_REGIONS(NR), .ADDR_W(AW)) i_region_guard (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .acc_addr, .acc_write, .acc_secure, .acc_allow
    );

    function automatic logic [63:0] aw_mask();
        return {64{1'b1}} >> (64 - AW);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_en[i] = 1'b0; m_size[i] = '0; m_perm[i] = '0;
        end
        m_inv = 1'b0;
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        int idx;
        if (a[1:0] != 2'b00) return;
        if (a == 12'h034) begin m_inv = d[0]; return; end
        if (a[11:8] != 4'h1) return;
        idx = int'(a[7:4]);
        if (idx >= NR) return;
        case (a[3:2])
            2'd0: m_base[idx][31:0]  = d & aw_mask()[31:0];
            2'd1: m_base[idx][63:32] = d & aw_mask()[63:32];
            2'd2: begin m_en[idx] = d[0]; m_size[idx] = d[6:1]; m_perm[idx] = d[31:28]; end
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        int idx;
        if (a[1:0] != 2'b00) return 32'd0;
        if (a == 12'h000) return {18'd0, 6'(AW-1), 4'd0, 4'(NR-1)};
        if (a == 12'h034) return {31'd0, m_inv};
        if (a[11:8] != 4'h1) return 32'd0;
        idx = int'(a[7:4]);
        if (idx >= NR) return 32'd0;
        case (a[3:2])
            2'd0: return m_base[idx][31:0];
            2'd1: return m_base[idx][63:32];
            2'd2: return {m_perm[idx], 21'd0, m_size[idx], m_en[idx]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit model_hit(int i, logic [AW-1:0] a);
        int se;
        logic [AW-1:0] x;
        se = (m_size[i] < 6'd14) ? 14 : int'(m_size[i]);
        if (se + 1 >= AW) return 1'b1;
        x = a ^ m_base[i][AW-1:0];
        return (x >> (se + 1)) == '0;
    endfunction

    function automatic logic model_allow(logic [AW-1:0] a, logic w, logic s);
        logic [3:0] p;
        p = m_perm[0];
        for (int i = 1; i < NR; i++) begin
            if (m_en[i] && model_hit(i, a)) p = m_perm[i];
        end
        if (s) return w ? p[2] : p[3];
        return w ? p[0] : p[1];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, model_read(a));
    endtask

    task automatic acc_chk(input string req, input logic [AW-1:0] a, input logic w, input logic s);
        acc_addr = a; acc_write = w; acc_secure = s;
        #1;
        chk(req, {31'd0, acc_allow}, {31'd0, model_allow(a, w, s)});
    endtask

    task automatic acc_all(input string req, input logic [AW-1:0] a);
        for (int k = 0; k < 4; k++) acc_chk(req, a, k[0], k[1]);
    endtask

    function automatic logic [11:0] rofs(int n, int slot);
        return 12'(12'h100 + 16 * n + 4 * slot);
    endfunction

    initial begin : watchdog
        #(CLK_P * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [AW-1:0] a;
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 attr0", rofs(0, 2));
        rd_chk("R1 base3", rofs(3, 0));
        rd_chk("R1 inv", 12'h034);
        acc_all("R1 deny", 40'h12_3456_7890);

        // R2: build word 0x2704 for 5 regions, 40 bits
        reg_addr = 12'h000; #1;
        chk("R2 build", reg_rdata, 32'h0000_2704);
        wr(12'h000, 32'hFFFF_FFFF);
        rd_chk("R2 build after write", 12'h000);

        // R3: readback masking
        wr(rofs(1, 1), 32'hFFFF_FFFF);
        reg_addr = rofs(1, 1); #1;
        chk("R3 base high truncated", reg_rdata, 32'h0000_00FF);
        wr(rofs(1, 2), 32'hFFFF_FFFE);
        reg_addr = rofs(1, 2); #1;
        chk("R3 attr bits", reg_rdata, 32'hF000_007E);
        rd_chk("R3 fourth slot", rofs(1, 3));
        wr(rofs(1, 0), 32'hDEAD_BEEF);
        rd_chk("R3 base low", rofs(1, 0));
        wr(rofs(1, 1), 32'h0);
        wr(rofs(1, 2), 32'h0);

        // R8 / R9: background region with all permissions, disabled, odd base
        wr(rofs(0, 0), 32'h0080_0000);
        wr(rofs(0, 2), 32'hF000_0000 | (6'd14 << 1));
        acc_all("R8 background any address", 40'hAB_0000_0001);
        for (int b = 0; b < 4; b++) begin
            wr(rofs(0, 2), 32'(1 << (28 + b)));
            acc_all("R9 single permission bit", 40'h00_0000_1000);
        end

        // R5: region 1 at 0x800000, 2 MB, deny; background allows all
        wr(rofs(0, 2), 32'hF000_0000);
        wr(rofs(1, 0), 32'h0080_0000);
        wr(rofs(1, 2), 32'h0000_0001 | (6'h14 << 1));
        acc_chk("R5 inside base", 40'h00_0080_0000, 1'b0, 1'b1);
        chk("R5 inside base denied", {31'd0, acc_allow}, 32'd0);
        acc_chk("R5 inside top", 40'h00_009F_FFFF, 1'b1, 1'b0);
        acc_chk("R5 just above", 40'h00_00A0_0000, 1'b1, 1'b0);
        chk("R5 just above allowed", {31'd0, acc_allow}, 32'd1);
        acc_chk("R5 just below", 40'h00_007F_FFFF, 1'b0, 1'b0);
        acc_chk("R5 high bits differ", 40'h01_0080_0000, 1'b0, 1'b0);
        wr(rofs(1, 2), 32'h0000_0001 | (6'd39 << 1));
        acc_chk("R5 whole space", 40'hFF_FFFF_FFFF, 1'b0, 1'b1);
        chk("R5 whole space denied", {31'd0, acc_allow}, 32'd0);

        // R6: small codes clamp to 32 KB
        wr(rofs(1, 2), 32'h0000_0001 | (6'd3 << 1));
        acc_chk("R6 clamp inside", 40'h00_0080_7FFF, 1'b0, 1'b0);
        chk("R6 clamp inside denied", {31'd0, acc_allow}, 32'd0);
        acc_chk("R6 clamp outside", 40'h00_0080_8000, 1'b0, 1'b0);
        rd_chk("R6 code kept", rofs(1, 2));

        // R4: disable region 1
        wr(rofs(1, 2), 32'h0000_0000 | (6'h14 << 1));
        acc_chk("R4 disabled", 40'h00_0080_0000, 1'b0, 1'b1);
        chk("R4 disabled allowed", {31'd0, acc_allow}, 32'd1);

        // R7: overlapping regions
        wr(rofs(1, 2), 32'h0000_0001 | (6'h14 << 1));
        wr(rofs(2, 0), 32'h0080_0000);
        wr(rofs(2, 2), 32'hF000_0001 | (6'h12 << 1));
        acc_chk("R7 higher wins", 40'h00_0080_0000, 1'b1, 1'b1);
        chk("R7 region2 allows", {31'd0, acc_allow}, 32'd1);
        acc_chk("R7 only region1", 40'h00_0090_0000, 1'b1, 1'b1);
        wr(rofs(3, 0), 32'h0080_0000);
        wr(rofs(3, 2), 32'h0000_0001 | (6'h10 << 1));
        acc_chk("R7 region3 over region2", 40'h00_0080_0100, 1'b0, 1'b1);
        chk("R7 region3 denies", {31'd0, acc_allow}, 32'd0);

        // R10: write takes effect only after the accepting edge
        @(negedge clk);
        acc_addr = 40'h00_0080_0100; acc_write = 1'b0; acc_secure = 1'b1;
        reg_we = 1'b1; reg_addr = rofs(3, 2); reg_wdata = 32'h8000_0001 | (6'h10 << 1);
        #1;
        chk("R10 before edge", {31'd0, acc_allow}, 32'd0);
        @(negedge clk);
        reg_we = 1'b0;
        model_write(rofs(3, 2), 32'h8000_0001 | (6'h10 << 1));
        #1;
        chk("R10 after edge", {31'd0, acc_allow}, 32'd1);

        // R11: out-of-range, unaligned, unmapped
        wr(rofs(5, 2), 32'hF000_0001);
        reg_addr = rofs(5, 2); #1;
        chk("R11 oob read zero", reg_rdata, 32'd0);
        wr(rofs(15, 0), 32'h0000_0000);
        acc_all("R11 oob no effect", 40'h00_0080_0100);
        wr(rofs(4, 2) | 12'h1, 32'hF000_0001);
        rd_chk("R11 unaligned write ignored", rofs(4, 2));
        reg_addr = rofs(1, 0) | 12'h2; #1;
        chk("R11 unaligned read zero", reg_rdata, 32'd0);
        reg_addr = 12'h040; #1;
        chk("R11 unmapped read zero", reg_rdata, 32'd0);

        // R12: inversion bit
        wr(12'h034, 32'hFFFF_FFFF);
        reg_addr = 12'h034; #1;
        chk("R12 inv readback", reg_rdata, 32'd1);
        acc_all("R12 no decision change", 40'h00_0080_0100);
        acc_all("R12 no decision change bg", 40'h00_4000_0000);

        // Random mix: R3 R5 R6 R7 R9 R11
        for (int it = 0; it < 600; it++) begin
            int kind;
            int rn;
            int sl;
            kind = int'($urandom % 3);
            rn = int'($urandom % 7);
            sl = int'($urandom % 4);
            if (kind == 0) begin
                case (sl)
                    0: d = $urandom & 32'h00F8_0000;
                    1: d = $urandom & 32'h0000_0001;
                    default: begin
                        d = $urandom;
                        d[6:1] = 6'(10 + ($urandom % 14));
                    end
                endcase
                wr(rofs(rn, sl), d);
            end else if (kind == 1) begin
                rd_chk("R3 R11 random readback", rofs(rn, sl));
            end else begin
                @(negedge clk);
                a = {7'd0, 1'($urandom), ($urandom & 32'h00FF_FFFF)};
                acc_chk("R5 R7 R9 random access", a, 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule